// File: doc/BRIEF.md
# Byte-Write Completion Sequencer

This block sits on the master side of a serial in-system programming link. It takes one byte-write request, for either the program flash or the data EEPROM of a target device. It issues the matching four-byte write command through an attached SPI command engine. It then decides when the target is ready for the next write. It has two ways to decide. In polled operation it reads the same location back, again and again, until the target returns the byte it was given. In timed operation it simply waits a fixed number of system clocks.

While a write is still in progress, the target answers a read of that location with a busy sentinel (by default 0xFF). A byte equal to that sentinel therefore cannot be confirmed by read-back. For such a byte the sequencer quietly falls back to the fixed wait, even when polling was requested. A poll that never sees the written value gives up after a parameterized number of read frames. It then reports an error together with its completion pulse.

Top module: `write_poll_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `done`, `err` and `frm_valid` are 0.
- R2: A write frame is `frm_word` = {opcode[31:24], address high[23:16], address low[15:8], data[7:0]}. The opcode is 0x60 for the flash low byte, 0x68 for the flash high byte (bit 3 carries `req_hi`), and 0xC0 for EEPROM, where `req_hi` is ignored.
- R3: Once `frm_valid` is raised, it stays high and `frm_word` stays unchanged until a cycle in which `frm_ready` is 1 takes the frame.
- R4: In polled operation, with a data byte different from SENTINEL, every response to a write frame or a failed read is followed by a read frame {read opcode, same address high, same address low, 0x00}. The read opcode is 0x20 or 0x28 for flash, selected by `req_hi` in bit 3, and 0xA0 for EEPROM.
- R5: A polled write finishes on the clock edge that samples a read response equal to the written byte. On that edge `done` becomes 1 for one cycle and `err` stays 0.
- R6: If MAX_POLLS read responses all differ from the written byte, `done` and `err` both become 1 on the edge that samples the last one, and no further read frame is issued.
- R7: In polled operation, a data byte equal to SENTINEL issues no read frame and completes exactly as in R8.
- R8: In timed operation (`req_polled` = 0), no read frame is issued. `done` becomes 1 exactly DELAY_CYC clock edges after the edge that samples the write frame's response, and `err` stays 0.
- R9: `ready` is 1 only while idle. It drops on the edge that accepts `req_valid`, and `done` is a single-cycle pulse that coincides with `ready` returning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is 1 |
| req_eeprom | input | 1 | 1 selects EEPROM, 0 selects flash |
| req_hi | input | 1 | Flash byte select, 1 = high byte of the word |
| req_addr | input | 16 | Word (flash) or byte (EEPROM) address |
| req_data | input | 8 | Byte to program |
| req_polled | input | 1 | 1 = read-back polling, 0 = fixed wait |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit reached, valid with `done` |
| frm_valid | output | 1 | Command frame offered to the SPI engine |
| frm_word | output | 32 | Four command bytes, first byte in [31:24] |
| frm_ready | input | 1 | Engine takes the offered frame |
| rsp_valid | input | 1 | Engine returns the fourth received byte |
| rsp_byte | input | 8 | Fourth byte clocked in from the target |

## Verification
The checker relies on the SPI engine behaving well. It must return exactly one `rsp_valid` pulse per accepted frame, and only after it has taken that frame. It must never return a response while no frame is outstanding. The bench engine model keeps to this by serving one frame at a time: it takes the frame, waits two cycles, and sends back a single response pulse. Requests are made only while `ready` is 1. The bench sweeps both memories, both byte selects, both modes, a normal byte and the sentinel byte, and a range of busy-read counts that runs past the poll limit.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam logic [7:0] OP_FLASH_RD = 8'h20;
    localparam logic [7:0] OP_FLASH_WR = 8'h60;
    localparam logic [7:0] OP_EE_RD    = 8'hA0;
    localparam logic [7:0] OP_EE_WR    = 8'hC0;
    localparam int         HI_BIT      = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND_WR,
        ST_WAIT_WR,
        ST_DELAY,
        ST_SEND_RD,
        ST_WAIT_RD
    } wpc_state_t;

    typedef struct packed {
        logic        eeprom;
        logic        hi;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        polled;
    } wr_req_t;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] addr_hi;
        logic [7:0] addr_lo;
        logic [7:0] data;
    } frame_t;

    function automatic logic [7:0] rd_opcode(input logic eeprom, input logic hi);
        logic [7:0] op;
        op = eeprom ? OP_EE_RD : OP_FLASH_RD;
        if (!eeprom) op[HI_BIT] = hi;
        return op;
    endfunction

    function automatic logic [7:0] wr_opcode(input logic eeprom, input logic hi);
        logic [7:0] op;
        op = eeprom ? OP_EE_WR : OP_FLASH_WR;
        if (!eeprom) op[HI_BIT] = hi;
        return op;
    endfunction

endpackage

// File: rtl/wpc_frame_build.sv
module wpc_frame_build
    import wpc_pkg::*;
(
    input  wr_req_t req,
    input  logic    is_read,
    output frame_t  frame
);
    always_comb begin
        frame.op      = is_read ? rd_opcode(req.eeprom, req.hi)
                                : wr_opcode(req.eeprom, req.hi);
        frame.addr_hi = req.addr[15:8];
        frame.addr_lo = req.addr[7:0];
        frame.data    = is_read ? 8'h00 : req.data;
    end
endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/write_poll_ctrl.sv
module write_poll_ctrl
    import wpc_pkg::*;
#(
    parameter int         DELAY_CYC = 40000,
    parameter int         MAX_POLLS = 64,
    parameter logic [7:0] SENTINEL  = 8'hFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_eeprom,
    input  logic        req_hi,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_data,
    input  logic        req_polled,
    output logic        ready,
    output logic        done,
    output logic        err,
    output logic        frm_valid,
    output logic [31:0] frm_word,
    input  logic        frm_ready,
    input  logic        rsp_valid,
    input  logic [7:0]  rsp_byte
);
    wpc_state_t state_q;
    wr_req_t    req_q;
    frame_t     frame;
    logic       use_poll;
    logic       wr_rsp, rd_rsp;
    logic       dly_last, poll_last;

    assign use_poll = req_q.polled && (req_q.data != SENTINEL);
    assign wr_rsp   = (state_q == ST_WAIT_WR) && rsp_valid;
    assign rd_rsp   = (state_q == ST_WAIT_RD) && rsp_valid;

    wpc_frame_build u_build (
        .req     (req_q),
        .is_read (state_q == ST_SEND_RD),
        .frame   (frame)
    );

    wpc_counter #(.LIMIT(DELAY_CYC)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .clr  (wr_rsp),
        .inc  (state_q == ST_DELAY),
        .last (dly_last)
    );

    wpc_counter #(.LIMIT(MAX_POLLS)) u_polls (
        .clk  (clk),
        .rst  (rst),
        .clr  (wr_rsp),
        .inc  (rd_rsp),
        .last (poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q   <= '{eeprom: req_eeprom, hi: req_hi, addr: req_addr,
                                     data: req_data, polled: req_polled};
                        state_q <= ST_SEND_WR;
                    end
                end
                ST_SEND_WR: if (frm_ready) state_q <= ST_WAIT_WR;
                ST_WAIT_WR: begin
                    if (rsp_valid) state_q <= use_poll ? ST_SEND_RD : ST_DELAY;
                end
                ST_DELAY: begin
                    if (dly_last) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                ST_SEND_RD: if (frm_ready) state_q <= ST_WAIT_RD;
                ST_WAIT_RD: begin
                    if (rsp_valid) begin
                        if (rsp_byte == req_q.data) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else if (poll_last) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                            err     <= 1'b1;
                        end else begin
                            state_q <= ST_SEND_RD;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ready     = (state_q == ST_IDLE);
    assign frm_valid = (state_q == ST_SEND_WR) || (state_q == ST_SEND_RD);
    assign frm_word  = frame;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter logic [7:0] SENTINEL = 8'hFF
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_polled,
    input logic [7:0]  req_data,
    input logic        ready,
    input logic        done,
    input logic        err,
    input logic        frm_valid,
    input logic [31:0] frm_word,
    input logic        frm_ready
);
    logic       poll_expected;
    logic [7:0] op;
    logic       is_rd_op;

    assign op       = frm_word[31:24];
    assign is_rd_op = (op == 8'h20) || (op == 8'h28) || (op == 8'hA0);

    always_ff @(posedge clk) begin
        if (rst) poll_expected <= 1'b0;
        else if (req_valid && ready) poll_expected <= req_polled && (req_data != SENTINEL);
    end

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !frm_ready |=> frm_valid && $stable(frm_word)); // R3
    AST_LEGAL_OPCODE: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> is_rd_op || op == 8'h60 || op == 8'h68 || op == 8'hC0); // R2
    AST_READ_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        frm_valid && is_rd_op |-> frm_word[7:0] == 8'h00); // R4
    AST_NO_POLL_WHEN_TIMED: assert property (@(posedge clk) disable iff (rst)
        frm_valid && is_rd_op |-> poll_expected); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> ready && !frm_valid); // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_valid && ready |=> !ready); // R9
endmodule

bind write_poll_ctrl wpc_checker #(.SENTINEL(SENTINEL)) u_wpc_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_polled (req_polled),
    .req_data   (req_data),
    .ready      (ready),
    .done       (done),
    .err        (err),
    .frm_valid  (frm_valid),
    .frm_word   (frm_word),
    .frm_ready  (frm_ready)
);

// File: tb/tb_write_poll_ctrl.sv
module tb_write_poll_ctrl;
    localparam int         DLY  = 5;
    localparam int         MAXP = 4;
    localparam logic [7:0] SENT = 8'hFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_eeprom = 1'b0, req_hi = 1'b0, req_polled = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        ready, done, err, frm_valid;
    logic [31:0] frm_word;
    logic        frm_ready = 1'b0, rsp_valid = 1'b0;
    logic [7:0]  rsp_byte = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    write_poll_ctrl #(.DELAY_CYC(DLY), .MAX_POLLS(MAXP), .SENTINEL(SENT)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_eeprom(req_eeprom),
        .req_hi(req_hi), .req_addr(req_addr), .req_data(req_data),
        .req_polled(req_polled), .ready(ready), .done(done), .err(err),
        .frm_valid(frm_valid), .frm_word(frm_word), .frm_ready(frm_ready),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wait_frame(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (frm_valid) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic take_frame();
        frm_ready = 1'b1;
        @(negedge clk);
        frm_ready = 1'b0;
    endtask

    task automatic respond(input logic [7:0] b);
        @(negedge clk);
        @(negedge clk);
        rsp_byte  = b;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic do_write(input bit ee, input bit hi, input logic [15:0] addr,
                            input logic [7:0] data, input bit polled, input int busy);
        logic [7:0]  rd_op, wr_op;
        logic [31:0] exp_word, held;
        bit          seen, timed, fin, exp_done, exp_err;
        int          n, cyc, exp_reads;
        logic [7:0]  b;

        rd_op = ee ? 8'hA0 : 8'h20 + (hi ? 8'd8 : 8'd0);
        wr_op = rd_op + (ee ? 8'h20 : 8'h40);
        timed = !polled || (data == SENT);

        check(ready == 1'b1, "R9 ready before request", 32'(ready), 1);
        req_valid = 1'b1; req_eeprom = ee; req_hi = hi; req_addr = addr;
        req_data = data; req_polled = polled;
        @(negedge clk);
        req_valid = 1'b0;
        check(ready == 1'b0, "R9 ready drops when busy", 32'(ready), 0);

        wait_frame(seen);
        exp_word = {wr_op, addr, data};
        check(seen && frm_word == exp_word, "R2 write frame", frm_word, exp_word);
        held = frm_word;
        @(negedge clk);
        check(frm_valid && frm_word == held, "R3 frame held", frm_word, held);
        take_frame();
        respond(addr[7:0]);

        if (timed) begin
            cyc = 1;
            while (!done && cyc < DLY + 10) begin
                check(!frm_valid, timed && polled ? "R7 no read frame" : "R8 no read frame",
                      32'(frm_valid), 0);
                @(negedge clk);
                cyc++;
            end
            check(cyc == DLY + 1, polled ? "R7 delay length" : "R8 delay length",
                  32'(cyc), 32'(DLY + 1));
            check(err == 1'b0, "R8 no error", 32'(err), 0);
        end else begin
            exp_reads = (busy + 1 > MAXP) ? MAXP : busy + 1;
            n = 0;
            fin = 1'b0;
            while (!fin && n < MAXP + 2) begin
                wait_frame(seen);
                exp_word = {rd_op, addr, 8'h00};
                check(seen && frm_word == exp_word, "R4 read frame", frm_word, exp_word);
                take_frame();
                b = (n < busy) ? SENT : data;
                respond(b);
                n++;
                exp_done = (b == data) || (n == MAXP);
                exp_err  = exp_done && (b != data);
                check(done == exp_done, exp_err ? "R6 done at limit" : "R5 done on match",
                      32'(done), 32'(exp_done));
                check(err == exp_err, exp_err ? "R6 error flag" : "R5 no error",
                      32'(err), 32'(exp_err));
                fin = exp_done || done;
            end
            check(n == exp_reads, busy + 1 > MAXP ? "R6 read count" : "R4 read count",
                  32'(n), 32'(exp_reads));
        end
        check(ready == 1'b1, "R9 ready with done", 32'(ready), 1);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", 32'(done), 0);
        check(!frm_valid, "R6 no frame after completion", 32'(frm_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(ready == 1'b1 && done == 1'b0 && err == 1'b0 && frm_valid == 1'b0,
              "R1 reset state", {28'd0, ready, done, err, frm_valid}, 32'h8);
        for (int ee = 0; ee < 2; ee++)
            for (int hi = 0; hi < 2; hi++)
                for (int pm = 0; pm < 2; pm++)
                    for (int dv = 0; dv < 2; dv++)
                        for (int bz = 0; bz < 6; bz++)
                            do_write(ee[0], hi[0], {7'd0, ee[0], 2'(hi), 6'(bz)},
                                     dv[0] ? SENT : 8'h3C + 8'(bz), pm[0], bz);
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        report();
        $finish;
    end
endmodule